// File: doc/BRIEF.md
# Page Buffer Load Controller

This block is the device-side controller of a page-organised nonvolatile memory model. A host drives a byte-wide bus with active-low chip-enable, write-enable and output-enable. Each qualified write strobe deposits one byte into a 128-byte page buffer. The buffer fills at any offset and in any order. When the host stops strobing for a programmable number of clock cycles, the controller starts an internally timed write cycle. That cycle commits the whole page to a behavioural storage array and raises `busy` until it is done.

All intervals are counted in clock cycles from parameters, so a simulation can shrink milliseconds to a few hundred cycles. The address splits into a page index (upper bits) and a byte offset (low 7 bits). The array depth follows the page-index width parameter. While `busy` is low, a host read with chip-enable and output-enable low returns the stored byte.

The controller is an FSM with three states:
- `ST_IDLE` moves to `ST_LOAD` on the first qualified byte load (transition *first_load*).
- `ST_LOAD` stays in place on each further load (*reload*). It moves to `ST_PROG` when the idle timer expires with no strobe active (*load_timeout*).
- `ST_PROG` returns to `ST_IDLE` after the programming count ends (*commit_done*). The buffer is written into the array on that transition.

Top module: `page_load_ctrl`

## Requirements
- R1: A page holds 128 bytes. Address bits [6:0] give the byte offset and bits [ADDR_W-1:7] give the page index. Stored byte (page p, offset o) is read back at address {p, o}.
- R2: A write strobe is active while ce_n=0, we_n=0 and oe_n=1, with the inputs sampled on each clock edge. The address is taken on the first active sample. The data is the value present on the last active sample.
- R3: Byte loads whose spacing stays below TIMEOUT_CYC cycles keep the controller in the load phase with `busy` low, for any number of loads.
- R4: When a load ends and no new strobe starts, `busy` is first seen high TIMEOUT_CYC+2 clock cycles after the first edge that samples the strobe released.
- R5: Loading an offset again overwrites its buffered byte. The page committed is the page index of the last byte loaded.
- R6: Every offset not loaded since the previous commit is written as 0xFF. This applies even when the array held other data there.
- R7: `busy` stays high for exactly PROG_CYC cycles once raised. Byte loads attempted during that time change neither the buffer nor the array, and they start no later write cycle.
- R8: No byte is loaded when oe_n is low or ce_n is high during the strobe. No byte is loaded when the strobe is active for fewer than GLITCH_CYC samples.
- R9: After reset `busy` is low and every array byte reads 0xFF.
- R10: With ce_n=0, oe_n=0, we_n=1 and `busy` low, `dout_en` is high and `dout` shows the array byte at `addr`, one clock after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address: page index above bit 7, offset in bits [6:0] |
| din | input | 8 | Write data |
| dout | output | 8 | Read data (zero when not enabled) |
| dout_en | output | 1 | Read data valid |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The embedded assertions check these properties on every cycle:
- The latched load address holds still through a strobe.
- A load timeout never fires while a strobe is active or a byte is arriving.
- `busy` never drops before the programming count ends.
- No buffer write happens while busy.
- A commit empties the buffer's loaded-offset flags.

Some behaviour only the bench scenarios can show, by reading the array back through the bus:
- exact timeout and programming durations;
- overwriting of a reloaded offset;
- retargeting to the last page;
- 0xFF fill of unloaded offsets;
- rejection of glitches and inhibited strobes.

// File: rtl/plc_pkg.sv
package plc_pkg;
    localparam int OFS_W  = 7;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ERASED = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } plc_state_t;
endpackage

// File: rtl/plc_strobe.sv
module plc_strobe
    import plc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int GLITCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic              act,
    output logic              ld_pulse,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [BYTE_W-1:0] ld_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int WID_W = $clog2(GLITCH_CYC + 1);

    logic              ce_q, we_q, oe_q, act_d;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] din_q;
    logic [WID_W-1:0]  width;

    assign act      = !ce_q && !we_q && oe_q;
    assign ld_pulse = !act && act_d && (width >= WID_W'(GLITCH_CYC));
    assign rd_en    = !ce_q && !oe_q && we_q;
    assign rd_addr  = addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q    <= 1'b1;
            we_q    <= 1'b1;
            oe_q    <= 1'b1;
            addr_q  <= '0;
            din_q   <= '0;
            act_d   <= 1'b0;
            width   <= '0;
            ld_addr <= '0;
            ld_data <= '0;
        end else begin
            ce_q   <= ce_n;
            we_q   <= we_n;
            oe_q   <= oe_n;
            addr_q <= addr;
            din_q  <= din;
            act_d  <= act;
            if (act) begin
                ld_data <= din_q;
                if (!act_d) begin
                    ld_addr <= addr_q;
                    width   <= WID_W'(1);
                end else if (width != WID_W'(GLITCH_CYC)) begin
                    width <= width + WID_W'(1);
                end
            end
        end
    end

    // R2: the load address is frozen once the strobe is under way
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act && act_d) |=> $stable(ld_addr));
endmodule

// File: rtl/plc_page_buf.sv
module plc_page_buf
    import plc_pkg::*;
#(
    parameter int PG_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [PG_W+OFS_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  commit,
    input  logic [PG_W+OFS_W-1:0] rd_addr,
    output logic [BYTE_W-1:0]     rd_data
);
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int DEPTH      = PAGE_BYTES << PG_W;

    logic [BYTE_W-1:0]     pbuf [PAGE_BYTES];
    logic [BYTE_W-1:0]     mem  [DEPTH];
    logic [PAGE_BYTES-1:0] valid;
    logic [PG_W-1:0]       page_r;
    logic [OFS_W-1:0]      wr_ofs;

    assign wr_ofs  = wr_addr[OFS_W-1:0];
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (wr) pbuf[wr_ofs] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= '0;
            page_r <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else begin
            if (wr) begin
                valid[wr_ofs] <= 1'b1;
                page_r        <= wr_addr[PG_W+OFS_W-1:OFS_W];
            end
            if (commit) begin
                for (int i = 0; i < PAGE_BYTES; i++)
                    mem[{page_r, OFS_W'(i)}] <= valid[i] ? pbuf[i] : ERASED;
                valid <= '0;
            end
        end
    end

    // R6: after a commit no offset is still marked loaded
    p_commit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (valid == '0));
    // R5: a written offset is marked loaded afterwards
    p_wr_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !commit) |=> valid[$past(wr_ofs)]);
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
    import plc_pkg::*;
#(
    parameter int PG_W        = 3,
    parameter int TIMEOUT_CYC = 40,
    parameter int PROG_CYC    = 100,
    parameter int GLITCH_CYC  = 2,
    parameter int ADDR_W      = PG_W + 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy
);
    localparam int MAX_CYC = (TIMEOUT_CYC > PROG_CYC) ? TIMEOUT_CYC : PROG_CYC;
    localparam int TICK_W  = $clog2(MAX_CYC + 1);

    plc_state_t        state, state_n;
    logic [TICK_W-1:0] tick;
    logic              strb_act, ld_pulse, ld_ok, buf_wr, commit, rd_en;
    logic [ADDR_W-1:0] ld_addr, rd_addr;
    logic [7:0]        ld_data, rd_data;

    plc_strobe #(.ADDR_W(ADDR_W), .GLITCH_CYC(GLITCH_CYC)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .act(strb_act), .ld_pulse(ld_pulse),
        .ld_addr(ld_addr), .ld_data(ld_data), .rd_en(rd_en), .rd_addr(rd_addr)
    );

    plc_page_buf #(.PG_W(PG_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr(buf_wr), .wr_addr(ld_addr),
        .wr_data(ld_data), .commit(commit), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign ld_ok = ld_pulse && (state != ST_PROG);

    // next state and strobes to the buffer
    always_comb begin
        state_n = state;
        buf_wr  = 1'b0;
        commit  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ld_ok) begin
                    buf_wr  = 1'b1;
                    state_n = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (ld_ok) begin
                    buf_wr = 1'b1;
                end else if (!strb_act && tick == TICK_W'(TIMEOUT_CYC - 1)) begin
                    state_n = ST_PROG;
                end
            end
            ST_PROG: begin
                if (tick == TICK_W'(PROG_CYC - 1)) begin
                    commit  = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register and interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tick  <= '0;
        end else begin
            state <= state_n;
            if (state_n != state)
                tick <= '0;
            else if (state == ST_LOAD && (strb_act || ld_ok))
                tick <= '0;
            else if (state != ST_IDLE)
                tick <= tick + TICK_W'(1);
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= (state_n == ST_PROG);
    end

    assign dout_en = rd_en && !busy;
    assign dout    = dout_en ? rd_data : 8'h00;

    // R4: the write cycle never begins while a strobe is active or a byte lands
    p_quiet_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && state_n == ST_PROG) |-> (!strb_act && !ld_pulse));
    // R7: once programming, busy holds until the final count
    p_prog_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick != TICK_W'(PROG_CYC - 1)) |=> busy);
    // R7: nothing enters the buffer while busy
    p_no_wr_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_wr);
endmodule

// File: tb/page_load_ctrl_bench.sv
`timescale 1ns/1ps
module page_load_ctrl_bench;
    localparam int PG_W = 3;
    localparam int TO   = 40;
    localparam int PR   = 100;
    localparam int GL   = 2;
    localparam int AW   = PG_W + 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en, busy;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [AW-1:0] a;
        logic [7:0]    d;
        string         tag;
    } exp_t;
    exp_t exp_q [$];

    always #2.5 clk = ~clk;

    page_load_ctrl #(.PG_W(PG_W), .TIMEOUT_CYC(TO), .PROG_CYC(PR), .GLITCH_CYC(GL)) u_page_load_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    function automatic logic [AW-1:0] pa(input int pg, input int ofs);
        return {PG_W'(pg), 7'(ofs)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected reads as the design presents data
    initial begin
        forever begin
            @(negedge clk);
            if (dout_en && exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (dout !== e.d) begin
                    fails++;
                    $display("FAIL %s addr=%0h actual=%0h expected=%0h", e.tag, e.a, dout, e.d);
                end
            end
        end
    end

    task automatic load_byte(input logic [AW-1:0] a, input logic [7:0] d,
                             input int w, input bit oe_lo, input bit ce_hi);
        @(negedge clk);
        addr = a; din = d; ce_n = ce_hi; we_n = 1'b0; oe_n = !oe_lo;
        repeat (w) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic read_exp(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        e.a = a; e.d = d; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    // waits for busy; returns negedges until busy seen and busy length
    task automatic wait_cycle(output int lead, output int len);
        lead = 0; len = 0;
        while (!busy && lead < 4 * TO) begin
            @(negedge clk);
            lead++;
        end
        while (busy && len < 4 * PR) begin
            @(negedge clk);
            len++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lead, len;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(busy == 1'b0, "R9 busy after reset", busy, 0);
        read_exp(pa(0, 0), 8'hFF, "R9 erased array");
        read_exp(pa(7, 127), 8'hFF, "R9 erased array top");

        // R1 R2 R5: page 2, overwrite offset 5; R4 exact timeout, R7 exact length
        load_byte(pa(2, 0), 8'h12, 3, 0, 0);
        load_byte(pa(2, 5), 8'h34, 3, 0, 0);
        load_byte(pa(2, 127), 8'h56, 3, 0, 0);
        load_byte(pa(2, 5), 8'h9A, 4, 0, 0);
        wait_cycle(lead, len);
        chk(lead == TO + 2, "R4 busy onset", lead, TO + 2);
        chk(len == PR, "R7 busy length", len, PR);
        read_exp(pa(2, 0), 8'h12, "R1 page2 ofs0");
        read_exp(pa(2, 5), 8'h9A, "R5 overwrite ofs5");
        read_exp(pa(2, 127), 8'h56, "R1 page2 ofs127");
        read_exp(pa(2, 1), 8'hFF, "R6 unloaded ofs1");
        read_exp(pa(3, 0), 8'hFF, "R1 next page untouched");

        // R5: page retarget to the last loaded page
        load_byte(pa(1, 3), 8'h11, 3, 0, 0);
        load_byte(pa(4, 9), 8'h22, 3, 0, 0);
        wait_cycle(lead, len);
        read_exp(pa(4, 3), 8'h11, "R5 retarget ofs3");
        read_exp(pa(4, 9), 8'h22, "R5 retarget ofs9");
        read_exp(pa(1, 3), 8'hFF, "R5 first page untouched");

        // R8: glitch, oe-low and ce-high strobes load nothing
        load_byte(pa(0, 0), 8'h44, 1, 0, 0);
        load_byte(pa(0, 2), 8'h33, 3, 1, 0);
        load_byte(pa(0, 3), 8'h77, 3, 0, 1);
        repeat (TO + 10) @(negedge clk);
        chk(busy == 1'b0, "R8 no cycle from rejected strobes", busy, 0);
        load_byte(pa(0, 1), 8'h66, 3, 0, 0);
        wait_cycle(lead, len);
        read_exp(pa(0, 1), 8'h66, "R8 good load");
        read_exp(pa(0, 0), 8'hFF, "R8 glitch rejected");
        read_exp(pa(0, 2), 8'hFF, "R8 oe-low rejected");
        read_exp(pa(0, 3), 8'hFF, "R8 ce-high rejected");

        // R7: loads during busy are ignored
        load_byte(pa(5, 0), 8'hA5, 3, 0, 0);
        while (!busy) @(negedge clk);
        load_byte(pa(6, 0), 8'h55, 3, 0, 0);
        chk(busy == 1'b1, "R7 still busy during load", busy, 1);
        while (busy) @(negedge clk);
        repeat (TO + 10) @(negedge clk);
        chk(busy == 1'b0, "R7 no cycle after ignored load", busy, 0);
        read_exp(pa(5, 0), 8'hA5, "R7 committed page");
        read_exp(pa(6, 0), 8'hFF, "R7 ignored load");

        // R3: spaced loads hold the load phase
        for (int i = 0; i < 6; i++) begin
            load_byte(pa(3, i * 20), 8'(8'h80 + i), 3, 0, 0);
            repeat (TO - 8) @(negedge clk);
            chk(busy == 1'b0, "R3 load phase held", busy, 0);
        end
        wait_cycle(lead, len);
        for (int i = 0; i < 6; i++) read_exp(pa(3, i * 20), 8'(8'h80 + i), "R3 spaced byte");

        // R6: rewrite page 2 with one byte; old data elsewhere becomes FF
        load_byte(pa(2, 0), 8'hC3, 3, 0, 0);
        wait_cycle(lead, len);
        read_exp(pa(2, 0), 8'hC3, "R6 rewritten ofs0");
        read_exp(pa(2, 5), 8'hFF, "R6 stale ofs5 erased");
        read_exp(pa(2, 127), 8'hFF, "R6 stale ofs127 erased");

        // R10: read disabled while output enable high
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        chk(dout_en == 1'b0, "R10 no read with oe high", dout_en, 0);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all reads observed", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule